// File: doc/BRIEF.md
# Synchronous Reset and Idle Sequencer

This block sits beside an 8-bit controller core and owns two things: bringing the core out of reset, and parking the core in idle. The external reset pin is never used as an asynchronous reset. It is sampled by the oscillator clock, passed through a synchronizer, and accepted only after it has been seen high on two consecutive rising edges. A single-edge blip on the pin is discarded.

After release, the block holds the external bus strobes in their reset levels for two more oscillator periods. It then flags the whole first machine cycle so the core throws that fetch away and repeats it, and only then lets the core run. Port reset follows the internal reset with a fixed two-period lag on both edges.

Idle is entered when the core writes the idle control bit while running. It ends when an enabled interrupt is pending, or when a reset arrives. While idle, the core clock enable is low and both bus strobes are forced high.

Top module: `resetIdleCtrl`

## Requirements
- R1: With the reset pin changed between clock edges, `coreReset` goes high right after the fourth rising edge that samples the pin high, and goes low right after the third rising edge that samples it low.
- R2: A pin high for only one rising edge never raises `coreReset`.
- R3: `portResetEn` repeats `coreReset` delayed by exactly two clock cycles, on both the rising and the falling edge.
- R4: While `coreReset` is high, and for the two cycles after it falls, the overrides are active with ALE low and PSEN high (`aleOvr`=1, `aleLvl`=0, `psenOvr`=1, `psenLvl`=1). Outside reset, release and idle, both overrides are 0.
- R5: `fetchDiscard` is 1 for exactly 12 consecutive cycles, which is one machine cycle. It starts in the cycle right after the override window and returns to 0 afterwards.
- R6: When `idleSet` is 1 in the running state and no interrupt is pending, `idleBit` is 1 after the next edge and `cpuClkEn` is 0 while idle. `idleSet` has no effect during reset, release or the discard cycle.
- R7: While `idleBit` is 1, `aleOvr`=1, `aleLvl`=1, `psenOvr`=1 and `psenLvl`=1.
- R8: When `intPending` is 1 while idle, `idleBit` is 0 after the next edge. When `idleSet` and `intPending` are both 1 in the running state, the block stays running.
- R9: A qualified reset during idle clears `idleBit`, raises `coreReset` and runs the full release and discard sequence again.
- R10: Writing `idleSet` while already idle keeps the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstPin | input | 1 | Raw external reset pin, active high, asynchronous |
| idleSet | input | 1 | Core writes 1 to the idle control bit |
| intPending | input | 1 | An enabled interrupt is pending |
| coreReset | output | 1 | Internal synchronous reset for the core |
| portResetEn | output | 1 | Drives port pins to their reset state |
| cpuClkEn | output | 1 | Core clock enable, low in idle |
| fetchDiscard | output | 1 | Core must drop the current machine-cycle fetch |
| aleOvr | output | 1 | ALE override active |
| aleLvl | output | 1 | ALE level while overridden |
| psenOvr | output | 1 | PSEN override active |
| psenLvl | output | 1 | PSEN level while overridden |
| idleBit | output | 1 | Current value of the idle control bit |

## Verification
Each result arrives a fixed number of edges after its stimulus:
- `coreReset` rises after the fourth edge that sees the pin high and falls after the third edge that sees it low.
- `portResetEn` lags `coreReset` by two more edges.
- The overrides clear two edges after `coreReset` falls, at the same edge where `fetchDiscard` rises.
- Idle entry and exit take effect one edge after the input.

The bench changes inputs on the falling clock edge and samples after each rising edge. It checks every one of these edges individually, so an early or late transition is caught in the cycle where it happens. It counts the discard cycles rather than sampling only once.

// File: rtl/resetIdlePkg.sv
package resetIdlePkg;

  // Sequencer states; the all-zero code is the reset state.
  typedef enum logic [2:0] {
    stReset   = 3'd0,
    stRelease = 3'd1,
    stDiscard = 3'd2,
    stRun     = 3'd3,
    stIdle    = 3'd4
  } ctlState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadRelease;
    logic loadDiscard;
    logic cntDec;
  } dpStrobe_t;

endpackage

// File: rtl/resetIdleDp.sv
module resetIdleDp
  import resetIdlePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2,
  parameter int PORT_LAG    = 2,
  parameter int BUS_LAG     = 2,
  parameter int MC_LEN      = 12
) (
  input  logic      clk,
  input  logic      rstPin,
  input  logic      coreReset,
  input  dpStrobe_t strobe,
  output logic      rstHit,
  output logic      cntZero,
  output logic      portResetEn
);

  localparam int CHAIN   = SYNC_STAGES + QUAL_EDGES - 1;
  localparam int CNT_MAX = (BUS_LAG > MC_LEN) ? BUS_LAG : MC_LEN;
  localparam int CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(BUS_LAG - 1);
  localparam logic [CNT_W-1:0] MC_LOAD  = CNT_W'(MC_LEN - 1);

  // Synchronizer followed by qualification history, one shift chain.
  logic [CHAIN-1:0] pinChain;
  logic             syncOut;

  always_ff @(posedge clk) begin
    pinChain <= {pinChain[CHAIN-2:0], rstPin};
  end

  assign syncOut = pinChain[SYNC_STAGES-1];
  assign rstHit  = &pinChain[CHAIN-1 -: QUAL_EDGES];

  // Port reset delay line.
  generate
    if (PORT_LAG == 1) begin : gLagOne
      logic portQ;
      always_ff @(posedge clk) portQ <= coreReset;
      assign portResetEn = portQ;
    end else begin : gLagMany
      logic [PORT_LAG-1:0] portPipe;
      always_ff @(posedge clk) portPipe <= {portPipe[PORT_LAG-2:0], coreReset};
      assign portResetEn = portPipe[PORT_LAG-1];
    end
  endgenerate

  // Shared phase counter for the release window and the discard cycle.
  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (strobe.loadRelease)               phaseCnt <= REL_LOAD;
    else if (strobe.loadDiscard)          phaseCnt <= MC_LOAD;
    else if (strobe.cntDec && !cntZero)   phaseCnt <= phaseCnt - 1'b1;
  end

  assign cntZero = (phaseCnt == '0);

  // Internal reset drops only after the synchronized pin went low.
  AST_RELEASE_AFTER_SYNC: assert property (@(posedge clk) disable iff (rstPin)
    $fell(coreReset) |-> $past(!syncOut)); // R1

  // Port reset falls two cycles after the internal reset fell.
  AST_PORT_LAG: assert property (@(posedge clk) disable iff (rstPin)
    $fell(portResetEn) |-> $past(!coreReset, 2)); // R3

endmodule

// File: rtl/resetIdleCtl.sv
module resetIdleCtl
  import resetIdlePkg::*;
(
  input  logic      clk,
  input  logic      rstHit,
  input  logic      cntZero,
  input  logic      idleSet,
  input  logic      intPending,
  output dpStrobe_t strobe,
  output logic      coreReset,
  output logic      cpuClkEn,
  output logic      fetchDiscard,
  output logic      aleOvr,
  output logic      aleLvl,
  output logic      psenOvr,
  output logic      psenLvl,
  output logic      idleBit
);

  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (rstHit) begin
      nextState = stReset;
    end else begin
      case (state)
        stReset: begin
          nextState          = stRelease;
          strobe.loadRelease = 1'b1;
        end
        stRelease: begin
          if (cntZero) begin
            nextState          = stDiscard;
            strobe.loadDiscard = 1'b1;
          end else begin
            strobe.cntDec = 1'b1;
          end
        end
        stDiscard: begin
          if (cntZero) nextState = stRun;
          else         strobe.cntDec = 1'b1;
        end
        stRun: begin
          if (idleSet && !intPending) nextState = stIdle;
        end
        stIdle: begin
          if (intPending) nextState = stRun;
        end
        default: nextState = stReset;
      endcase
    end
  end

  logic inWindow;
  assign inWindow     = (state == stReset) || (state == stRelease);
  assign coreReset    = (state == stReset);
  assign idleBit      = (state == stIdle);
  assign fetchDiscard = (state == stDiscard);
  assign cpuClkEn     = !idleBit;
  assign aleOvr       = inWindow || idleBit;
  assign psenOvr      = inWindow || idleBit;
  assign aleLvl       = idleBit;
  assign psenLvl      = psenOvr;

  AST_DISCARD_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rstHit)
    $rose(fetchDiscard) |-> ($past(psenOvr) && !psenOvr)); // R5

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (coreReset)
    $rose(idleBit) |-> $past(idleSet && !intPending)); // R6

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (coreReset)
    idleBit |-> (aleLvl && psenLvl && !cpuClkEn)); // R7

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (coreReset)
    (idleBit && intPending) |=> !idleBit); // R8

endmodule

// File: rtl/resetIdleCtrl.sv
module resetIdleCtrl
  import resetIdlePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2,
  parameter int PORT_LAG    = 2,
  parameter int BUS_LAG     = 2,
  parameter int MC_LEN      = 12
) (
  input  logic clk,
  input  logic rstPin,
  input  logic idleSet,
  input  logic intPending,
  output logic coreReset,
  output logic portResetEn,
  output logic cpuClkEn,
  output logic fetchDiscard,
  output logic aleOvr,
  output logic aleLvl,
  output logic psenOvr,
  output logic psenLvl,
  output logic idleBit
);

  dpStrobe_t strobe;
  logic      rstHit;
  logic      cntZero;

  resetIdleDp #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_EDGES (QUAL_EDGES),
    .PORT_LAG   (PORT_LAG),
    .BUS_LAG    (BUS_LAG),
    .MC_LEN     (MC_LEN)
  ) u_dp (
    .clk        (clk),
    .rstPin     (rstPin),
    .coreReset  (coreReset),
    .strobe     (strobe),
    .rstHit     (rstHit),
    .cntZero    (cntZero),
    .portResetEn(portResetEn)
  );

  resetIdleCtl u_ctl (
    .clk         (clk),
    .rstHit      (rstHit),
    .cntZero     (cntZero),
    .idleSet     (idleSet),
    .intPending  (intPending),
    .strobe      (strobe),
    .coreReset   (coreReset),
    .cpuClkEn    (cpuClkEn),
    .fetchDiscard(fetchDiscard),
    .aleOvr      (aleOvr),
    .aleLvl      (aleLvl),
    .psenOvr     (psenOvr),
    .psenLvl     (psenLvl),
    .idleBit     (idleBit)
  );

endmodule

// File: tb/resetIdleCtrl_tb.sv
module resetIdleCtrl_tb;

  logic clk = 1'b0;
  logic rstPin = 1'b1;
  logic idleSet = 1'b0;
  logic intPending = 1'b0;
  logic coreReset, portResetEn, cpuClkEn, fetchDiscard;
  logic aleOvr, aleLvl, psenOvr, psenLvl, idleBit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  resetIdleCtrl u_dut (
    .clk(clk), .rstPin(rstPin), .idleSet(idleSet), .intPending(intPending),
    .coreReset(coreReset), .portResetEn(portResetEn), .cpuClkEn(cpuClkEn),
    .fetchDiscard(fetchDiscard), .aleOvr(aleOvr), .aleLvl(aleLvl),
    .psenOvr(psenOvr), .psenLvl(psenLvl), .idleBit(idleBit)
  );

  // Table rows: {idleSet, intPending, expected idleBit}, starting from run.
  localparam logic [2:0] VEC [0:7] = '{
    3'b101, 3'b001, 3'b101, 3'b010, 3'b010, 3'b110, 3'b101, 3'b110
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkOvr(input string req, input int ovr, input int aleL);
    chk(req, aleOvr, ovr);
    chk(req, psenOvr, ovr);
    chk(req, aleLvl, aleL);
    if (ovr != 0) chk(req, psenLvl, 1);
  endtask

  initial begin
    int nDisc;
    repeat (8) step();
    // reset state
    chk("R1 reset held", coreReset, 1);
    chk("R3 port reset held", portResetEn, 1);
    chkOvr("R4 overrides in reset", 1, 0);
    chk("R5 no discard in reset", fetchDiscard, 0);
    chk("R6 idle clear in reset", idleBit, 0);

    // release timing
    rstPin = 1'b0;
    step(); chk("R1 release edge1", coreReset, 1);
    step(); chk("R1 release edge2", coreReset, 1);
    step(); chk("R1 release edge3", coreReset, 0);
    chk("R3 port lag fall a", portResetEn, 1);
    chkOvr("R4 window 1", 1, 0);
    step(); chk("R3 port lag fall b", portResetEn, 1);
    chkOvr("R4 window 2", 1, 0);
    chk("R5 no discard in window", fetchDiscard, 0);
    step(); chk("R3 port released", portResetEn, 0);
    chkOvr("R4 overrides off", 0, 0);
    chk("R5 discard starts", fetchDiscard, 1);
    nDisc = 1;
    idleSet = 1'b1;
    step();
    chk("R6 idleSet ignored in discard", idleBit, 0);
    idleSet = 1'b0;
    for (int i = 0; i < 20 && fetchDiscard; i++) begin
      nDisc++;
      step();
    end
    chk("R5 discard length", nDisc, 12);
    chk("R5 running after discard", fetchDiscard, 0);
    chk("R6 clock enabled in run", cpuClkEn, 1);

    // idle table
    for (int v = 0; v < 8; v++) begin
      idleSet    = VEC[v][2];
      intPending = VEC[v][1];
      step();
      chk($sformatf("R6 R8 R10 row%0d idleBit", v), idleBit, VEC[v][0]);
      chk($sformatf("R6 row%0d cpuClkEn", v), cpuClkEn, !VEC[v][0]);
      chk($sformatf("R7 row%0d ale", v), aleOvr & aleLvl, VEC[v][0]);
      chk($sformatf("R7 row%0d psen", v), psenOvr & psenLvl, VEC[v][0]);
    end
    idleSet = 1'b0; intPending = 1'b0;
    step();

    // single-edge blip
    rstPin = 1'b1;
    step();
    rstPin = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R2 blip ignored", coreReset, 0);
      chk("R2 blip no port reset", portResetEn, 0);
      step();
    end

    // reset during idle
    idleSet = 1'b1; step(); idleSet = 1'b0;
    chk("R6 idle entered", idleBit, 1);
    rstPin = 1'b1;
    step(); chk("R1 assert edge1", coreReset, 0);
    step(); chk("R1 assert edge2", coreReset, 0);
    step(); chk("R1 assert edge3", coreReset, 0);
    chk("R9 still idle before reset", idleBit, 1);
    step(); chk("R1 assert edge4", coreReset, 1);
    chk("R9 idle cleared by reset", idleBit, 0);
    chk("R9 clock enabled", cpuClkEn, 1);
    chkOvr("R4 reset levels after idle", 1, 0);
    step(); chk("R3 port lag rise a", portResetEn, 0);
    step(); chk("R3 port lag rise b", portResetEn, 1);
    rstPin = 1'b0;
    repeat (5) step();
    chk("R9 discard reruns", fetchDiscard, 1);
    repeat (12) step();
    chk("R9 back to run", fetchDiscard | idleBit | aleOvr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule